// File: doc/BRIEF.md
# Transceiver Rate-Change Reset Sequencer

This block drives the reset and handshake lines around a dynamic PLL reconfiguration that changes the data rate of a serial transceiver channel. The receiver's clock-data-recovery runs in automatic lock mode. A single request starts a fixed run of steps:

1. The three channel resets go high.
2. The sequencer waits for the scan shifter to report that its last bit has left.
3. It pulses a configuration-update strobe.
4. It acknowledges completion of the scan.
5. It holds the PLL in asynchronous reset for a minimum time.
6. It releases the channel resets one by one as lock conditions and fixed delays allow.

Both lock inputs pass through a multi-flop synchronizer before the state machine uses them. A PLL that loses lock after the transmit side has been released makes the sequencer go back to the PLL reset step with every reset asserted again.

The block sits between a PLL scan-chain shifter and the transceiver's reset pins. A new request is taken only when the sequencer is idle. The `busy` output covers the whole run, and a one-cycle `done` pulse marks the final release.

Top module: `xrs_rate_reset_seq`

## Requirements
- R1: A request sampled while idle asserts the transmit-digital, receiver-analog and receiver-digital resets and `busy` on the next cycle. In that cycle the strobe, the acknowledge and the PLL reset stay low.
- R2: The configuration-update strobe is a single-cycle pulse. It appears in the cycle after `scan_complete_i` is sampled high in the scan-wait step, and never while the scan has not completed.
- R3: The scan-done acknowledge is a single-cycle pulse in the cycle directly after the configuration-update strobe. The PLL reset is low while either of them is high.
- R4: The PLL reset rises in the cycle after the acknowledge and stays high for exactly `PLL_RST_CYC` cycles (default 4). All three channel resets stay asserted during this time.
- R5: The transmit digital reset stays asserted until the PLL lock input is seen high after the PLL reset. It is released `SYNC_STAGES+1` cycles after `pll_lock_i` rises.
- R6: The receiver analog reset is released exactly `SETTLE_CYC` cycles (default 5) after the transmit digital reset is released.
- R7: After the receiver analog reset is released, the receiver digital reset is held until frequency lock is seen. It is released `SYNC_STAGES+1+LTD_CYC` cycles after `rx_freq_lock_i` rises.
- R8: The PLL lock input may fall during the settle wait, the frequency-lock wait or the lock-to-data delay. In that case, `SYNC_STAGES+1` cycles after the fall, the PLL reset and all three channel resets are high, and the PLL reset step then runs again as in R4.
- R9: A request that arrives while `busy` is high has no effect. The sequence timing is unchanged, and once the run ends all outputs stay low.
- R10: `done_o` is high for exactly one cycle: the cycle in which the receiver digital reset is released. In that cycle `busy_o` is already low.
- R11: While reset is asserted, and after it until a request arrives, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Parallel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reconfig_req_i | input | 1 | Start a rate-change sequence (taken only when idle) |
| scan_complete_i | input | 1 | Last scan bit has been shifted out |
| pll_lock_i | input | 1 | PLL locked, asynchronous |
| rx_freq_lock_i | input | 1 | Receiver frequency locked, asynchronous |
| tx_dig_rst_o | output | 1 | Transmit digital reset |
| rx_ana_rst_o | output | 1 | Receiver analog reset |
| rx_dig_rst_o | output | 1 | Receiver digital reset |
| cfg_update_o | output | 1 | Configuration-update strobe to the PLL |
| scan_ack_o | output | 1 | Scan-done acknowledge |
| pll_rst_o | output | 1 | PLL asynchronous reset |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse on final release |

## Verification
The bench sweeps the delay before scan completion, the delay before PLL lock and the delay before frequency lock. At every combination it measures each release interval in cycles against the synchronizer depth and the parameters. An off-by-one timer or a missing synchronizer stage would show up as a release one cycle early or late.

Lock is also dropped in each of the three wait steps. A design that restarted from the wrong step would skip the repeated PLL reset. A design that ignored the loss would release a receiver reset on a dead PLL.

Requests are injected in mid-sequence. A sequencer that accepted them would restart or lengthen a window, or start a second run after `done`.

// File: rtl/xrs_pkg.sv
package xrs_pkg;

   typedef enum logic [3:0] {
      ST_IDLE       = 4'd0,
      ST_WAIT_SCAN  = 4'd1,
      ST_CFG_UPD    = 4'd2,
      ST_SCAN_ACK   = 4'd3,
      ST_PLL_RST    = 4'd4,
      ST_WAIT_LOCK  = 4'd5,
      ST_SETTLE     = 4'd6,
      ST_WAIT_FLOCK = 4'd7,
      ST_LTD        = 4'd8
   } xrs_state_e;

   typedef struct packed {
      logic tx;
      logic rxa;
      logic rxd;
      logic cfg;
      logic ack;
      logic pll;
      logic busy;
   } xrs_out_t;

   // Output levels that belong to each step of the sequence.
   function automatic xrs_out_t xrs_decode(input xrs_state_e s);
      xrs_out_t o;
      o = '0;
      case (s)
         ST_IDLE: o = '0;
         ST_WAIT_SCAN: begin
            o.tx = 1'b1; o.rxa = 1'b1; o.rxd = 1'b1; o.busy = 1'b1;
         end
         ST_CFG_UPD: begin
            o.tx = 1'b1; o.rxa = 1'b1; o.rxd = 1'b1; o.busy = 1'b1;
            o.cfg = 1'b1;
         end
         ST_SCAN_ACK: begin
            o.tx = 1'b1; o.rxa = 1'b1; o.rxd = 1'b1; o.busy = 1'b1;
            o.ack = 1'b1;
         end
         ST_PLL_RST: begin
            o.tx = 1'b1; o.rxa = 1'b1; o.rxd = 1'b1; o.busy = 1'b1;
            o.pll = 1'b1;
         end
         ST_WAIT_LOCK: begin
            o.tx = 1'b1; o.rxa = 1'b1; o.rxd = 1'b1; o.busy = 1'b1;
         end
         ST_SETTLE: begin
            o.rxa = 1'b1; o.rxd = 1'b1; o.busy = 1'b1;
         end
         ST_WAIT_FLOCK, ST_LTD: begin
            o.rxd = 1'b1; o.busy = 1'b1;
         end
         default: o = '0;
      endcase
      return o;
   endfunction

endpackage

// File: rtl/xrs_sync.sv
module xrs_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("xrs_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("xrs_sync: WIDTH must be at least 1");
   end

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      logic [WIDTH-1:0] q;
      if (g == 0) begin : g_first
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) q <= '0;
            else         q <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) q <= '0;
            else         q <= g_stage[g-1].q;
         end
      end
   end

   assign q_o = g_stage[STAGES-1].q;

endmodule

// File: rtl/xrs_timer.sv
module xrs_timer #(
   parameter int W = 4
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   output logic         zero_o
);

   if (W < 1) begin : g_bad_w
      $error("xrs_timer: W must be at least 1");
   end

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            cnt_q <= '0;
      else if (load_i)        cnt_q <= load_val_i;
      else if (cnt_q != '0)   cnt_q <= cnt_q - W'(1);
   end

   assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/xrs_rate_reset_seq.sv
module xrs_rate_reset_seq
   import xrs_pkg::*;
#(
   parameter int PLL_RST_CYC = 4,
   parameter int SETTLE_CYC  = 5,
   parameter int LTD_CYC     = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic reconfig_req_i,
   input  logic scan_complete_i,
   input  logic pll_lock_i,
   input  logic rx_freq_lock_i,
   output logic tx_dig_rst_o,
   output logic rx_ana_rst_o,
   output logic rx_dig_rst_o,
   output logic cfg_update_o,
   output logic scan_ack_o,
   output logic pll_rst_o,
   output logic busy_o,
   output logic done_o
);

   localparam int MAX_AB  = (PLL_RST_CYC > SETTLE_CYC) ? PLL_RST_CYC : SETTLE_CYC;
   localparam int MAX_CYC = (MAX_AB > LTD_CYC) ? MAX_AB : LTD_CYC;
   localparam int CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

   if (PLL_RST_CYC < 1) begin : g_bad_pll
      $error("xrs_rate_reset_seq: PLL_RST_CYC must be at least 1");
   end
   if (SETTLE_CYC < 1) begin : g_bad_settle
      $error("xrs_rate_reset_seq: SETTLE_CYC must be at least 1");
   end
   if (LTD_CYC < 1) begin : g_bad_ltd
      $error("xrs_rate_reset_seq: LTD_CYC must be at least 1");
   end

   // Lock synchronizers
   logic [1:0] lock_raw;
   logic [1:0] lock_sync;
   logic       pll_lock_s;
   logic       rx_flock_s;

   assign lock_raw = {rx_freq_lock_i, pll_lock_i};

   xrs_sync #(
      .WIDTH (2),
      .STAGES(SYNC_STAGES)
   ) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (lock_raw),
      .q_o   (lock_sync)
   );

   assign pll_lock_s = lock_sync[0];
   assign rx_flock_s = lock_sync[1];

   // Shared interval timer
   logic             tmr_load;
   logic [CNT_W-1:0] tmr_val;
   logic             tmr_zero;

   xrs_timer #(
      .W(CNT_W)
   ) u_tmr (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (tmr_load),
      .load_val_i(tmr_val),
      .zero_o    (tmr_zero)
   );

   // Sequence state
   xrs_state_e state_q, state_d;
   xrs_out_t   out_q;
   logic       done_q, done_d;

   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      case (state_q)
         ST_IDLE: begin
            if (reconfig_req_i) state_d = ST_WAIT_SCAN;
         end
         ST_WAIT_SCAN: begin
            if (scan_complete_i) state_d = ST_CFG_UPD;
         end
         ST_CFG_UPD: begin
            state_d = ST_SCAN_ACK;
         end
         ST_SCAN_ACK: begin
            state_d  = ST_PLL_RST;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(PLL_RST_CYC - 1);
         end
         ST_PLL_RST: begin
            if (tmr_zero) state_d = ST_WAIT_LOCK;
         end
         ST_WAIT_LOCK: begin
            if (pll_lock_s) begin
               state_d  = ST_SETTLE;
               tmr_load = 1'b1;
               tmr_val  = CNT_W'(SETTLE_CYC - 1);
            end
         end
         ST_SETTLE: begin
            if (!pll_lock_s) begin
               state_d  = ST_PLL_RST;
               tmr_load = 1'b1;
               tmr_val  = CNT_W'(PLL_RST_CYC - 1);
            end else if (tmr_zero) begin
               state_d = ST_WAIT_FLOCK;
            end
         end
         ST_WAIT_FLOCK: begin
            if (!pll_lock_s) begin
               state_d  = ST_PLL_RST;
               tmr_load = 1'b1;
               tmr_val  = CNT_W'(PLL_RST_CYC - 1);
            end else if (rx_flock_s) begin
               state_d  = ST_LTD;
               tmr_load = 1'b1;
               tmr_val  = CNT_W'(LTD_CYC - 1);
            end
         end
         ST_LTD: begin
            if (!pll_lock_s) begin
               state_d  = ST_PLL_RST;
               tmr_load = 1'b1;
               tmr_val  = CNT_W'(PLL_RST_CYC - 1);
            end else if (tmr_zero) begin
               state_d = ST_IDLE;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   assign done_d = (state_q == ST_LTD) && pll_lock_s && tmr_zero;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         out_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         out_q   <= xrs_decode(state_d);
         done_q  <= done_d;
      end
   end

   assign tx_dig_rst_o = out_q.tx;
   assign rx_ana_rst_o = out_q.rxa;
   assign rx_dig_rst_o = out_q.rxd;
   assign cfg_update_o = out_q.cfg;
   assign scan_ack_o   = out_q.ack;
   assign pll_rst_o    = out_q.pll;
   assign busy_o       = out_q.busy;
   assign done_o       = done_q;

endmodule

// File: rtl/xrs_chk.sv
module xrs_chk #(
   parameter int PLL_RST_CYC = 4,
   parameter int SETTLE_CYC  = 5
) (
   input logic clk_i,
   input logic rst_ni,
   input logic reconfig_req_i,
   input logic scan_complete_i,
   input logic pll_lock_s,
   input logic rx_flock_s,
   input logic tx_dig_rst_o,
   input logic rx_ana_rst_o,
   input logic rx_dig_rst_o,
   input logic cfg_update_o,
   input logic scan_ack_o,
   input logic pll_rst_o,
   input logic busy_o,
   input logic done_o
);

   int pll_cnt;
   int settle_cnt;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pll_cnt    <= 0;
         settle_cnt <= 0;
      end else begin
         pll_cnt    <= pll_rst_o ? pll_cnt + 1 : 0;
         settle_cnt <= (!tx_dig_rst_o && rx_ana_rst_o) ? settle_cnt + 1 : 0;
      end
   end

   a_r1_start_resets: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(busy_o) |-> tx_dig_rst_o && rx_ana_rst_o && rx_dig_rst_o && $past(reconfig_req_i));

   a_r2_cfg_after_scan: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(cfg_update_o) |-> $past(scan_complete_i) && $past(busy_o));

   a_r2_cfg_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_update_o |=> !cfg_update_o);

   a_r3_ack_after_cfg: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(scan_ack_o) |-> $past(cfg_update_o));

   a_r3_one_handshake: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({cfg_update_o, scan_ack_o, pll_rst_o}));

   a_r4_pll_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(pll_rst_o) |-> pll_cnt == PLL_RST_CYC);

   a_r4_pll_all_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pll_rst_o |-> tx_dig_rst_o && rx_ana_rst_o && rx_dig_rst_o);

   a_r5_tx_needs_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(tx_dig_rst_o) |-> $past(pll_lock_s) && !pll_rst_o);

   a_r6_settle_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(rx_ana_rst_o) |-> settle_cnt == SETTLE_CYC);

   a_r7_dig_needs_flock: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(rx_dig_rst_o) |-> $past(rx_flock_s) && !rx_ana_rst_o);

   a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);

   a_r10_done_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> !busy_o && $fell(rx_dig_rst_o));

endmodule

bind xrs_rate_reset_seq xrs_chk #(
   .PLL_RST_CYC(PLL_RST_CYC),
   .SETTLE_CYC (SETTLE_CYC)
) u_chk (
   .clk_i          (clk_i),
   .rst_ni         (rst_ni),
   .reconfig_req_i (reconfig_req_i),
   .scan_complete_i(scan_complete_i),
   .pll_lock_s     (pll_lock_s),
   .rx_flock_s     (rx_flock_s),
   .tx_dig_rst_o   (tx_dig_rst_o),
   .rx_ana_rst_o   (rx_ana_rst_o),
   .rx_dig_rst_o   (rx_dig_rst_o),
   .cfg_update_o   (cfg_update_o),
   .scan_ack_o     (scan_ack_o),
   .pll_rst_o      (pll_rst_o),
   .busy_o         (busy_o),
   .done_o         (done_o)
);

// File: tb/sim_xrs_rate_reset_seq.sv
module sim_xrs_rate_reset_seq;

   localparam int PLL_C  = 4;
   localparam int SET_C  = 5;
   localparam int LTD_C  = 6;
   localparam int SYNC_N = 2;
   localparam int LAT    = SYNC_N + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req = 1'b0, scan = 1'b0, lock = 1'b0, flock = 1'b0;
   logic tx, rxa, rxd, cfg, ack, pll, busy, done;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   xrs_rate_reset_seq #(
      .PLL_RST_CYC(PLL_C),
      .SETTLE_CYC (SET_C),
      .LTD_CYC    (LTD_C),
      .SYNC_STAGES(SYNC_N)
   ) u0 (
      .clk_i          (clk),
      .rst_ni         (rst_n),
      .reconfig_req_i (req),
      .scan_complete_i(scan),
      .pll_lock_i     (lock),
      .rx_freq_lock_i (flock),
      .tx_dig_rst_o   (tx),
      .rx_ana_rst_o   (rxa),
      .rx_dig_rst_o   (rxd),
      .cfg_update_o   (cfg),
      .scan_ack_o     (ack),
      .pll_rst_o      (pll),
      .busy_o         (busy),
      .done_o         (done)
   );

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic pick(input int w);
      case (w)
         0: return tx;
         1: return rxa;
         2: return rxd;
         3: return pll;
         default: return 1'b0;
      endcase
   endfunction

   task automatic steps_until(input int w, input logic lvl, output int n);
      n = 0;
      do begin
         step();
         n++;
      end while (pick(w) != lvl && n < 200);
   endtask

   task automatic pll_hold(output int n);
      n = 0;
      while (pll && n < 200) begin
         n++;
         step();
      end
   endtask

   // Lock is lost, then the PLL reset step must repeat with all resets high.
   task automatic lose_lock(input string tag);
      int n;
      lock = 1'b0;
      flock = 1'b0;
      steps_until(3, 1'b1, n);
      chk({tag, " R8 loss to pll reset"}, n, LAT);
      chk({tag, " R8 resets back"}, {tx, rxa, rxd}, 3'b111);
   endtask

   task automatic run(input int sd, input int ld, input int fd, input int loss, input bit poke);
      int n;
      int left;
      bit fin;
      left = loss;
      req = 1'b1;
      step();
      req = 1'b0;
      chk("R1 resets on request", {tx, rxa, rxd, busy}, 4'b1111);
      chk("R1 handshake low", {cfg, ack, pll}, 3'b000);
      for (int i = 0; i < sd; i++) begin
         step();
         chk("R2 no strobe before scan", cfg, 0);
      end
      scan = 1'b1;
      if (poke) req = 1'b1;
      step();
      scan = 1'b0;
      req = 1'b0;
      chk("R2 strobe", {cfg, ack, pll}, 3'b100);
      step();
      chk("R3 ack after strobe", {cfg, ack, pll}, 3'b010);
      step();
      fin = 1'b0;
      while (!fin) begin
         pll_hold(n);
         chk("R4 pll reset length", n, PLL_C);
         chk("R4 resets held", {tx, rxa, rxd}, 3'b111);
         for (int i = 0; i < ld; i++) step();
         chk("R5 tx held before lock", tx, 1);
         lock = 1'b1;
         if (poke) req = 1'b1;
         steps_until(0, 1'b0, n);
         req = 1'b0;
         chk("R5 tx release latency", n, LAT);
         if (left == 1) begin
            left = 0;
            step();
            lose_lock("settle");
            continue;
         end
         steps_until(1, 1'b0, n);
         chk("R6 settle interval", n, SET_C);
         chk("R7 rx digital held", rxd, 1);
         if (left == 2) begin
            left = 0;
            for (int i = 0; i < fd; i++) step();
            lose_lock("flock wait");
            continue;
         end
         for (int i = 0; i < fd; i++) step();
         chk("R7 rx digital before flock", rxd, 1);
         flock = 1'b1;
         if (left == 3) begin
            left = 0;
            for (int i = 0; i < LAT + 1; i++) step();
            chk("R7 held inside delay", rxd, 1);
            lose_lock("ltd");
            continue;
         end
         steps_until(2, 1'b0, n);
         chk("R7 rx digital release", n, LAT + LTD_C);
         chk("R10 done with release", {done, busy}, 2'b10);
         fin = 1'b1;
      end
      step();
      chk("R10 done one cycle", done, 0);
      for (int i = 0; i < 3; i++) begin
         step();
         chk("R9 idle after run", {tx, rxa, rxd, cfg, ack, pll, busy, done}, 0);
      end
   endtask

   initial begin
      #(4 * 150000);
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      step();
      chk("R11 outputs in reset", {tx, rxa, rxd, cfg, ack, pll, busy, done}, 0);
      step();
      rst_n = 1'b1;
      for (int i = 0; i < 4; i++) begin
         step();
         chk("R11 idle after reset", {tx, rxa, rxd, cfg, ack, pll, busy, done}, 0);
      end
      for (int sd = 0; sd < 3; sd++)
         for (int ld = 0; ld < 4; ld++)
            for (int fd = 0; fd < 3; fd++)
               for (int loss = 0; loss < 4; loss++) begin
                  lock = 1'b0;
                  flock = 1'b0;
                  run(sd, ld, fd, loss, (ld % 2) == 1);
               end
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule